// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between a host write port and the write state machine (WSM) of a flash-style memory. It watches every host write. Each write carries a low address and a data byte. The block recognises command sequences that start with a fixed two-write unlock. Three-write commands end on the third write. Six-write commands send a set-up code, repeat the unlock, and then send the final code. An accepted command that needs WSM action produces a one-cycle request. The request carries an operation code and the sector field from the final write.

The block also keeps the read-path selection: array data, status or identifier. It records whether an erase has been suspended. It filters commands against the WSM activity reported on its busy inputs, so that only the commands valid in the current situation take effect. A write that does not fit the sequence in progress, or a finished command that is not accepted, is dropped. The decoder then waits for a new unlock.

Top module: `cmdseq_decoder`

## Requirements
- R1: A sequence starts with data AAh at low address 5555h, followed by data 55h at low address 2AAAh. Only address bits 14..0 are compared. Bits above 14 do not affect the match.
- R2: A third write of A0h to low address 5555h issues a program request (req_op 1). req_valid and req_op appear in the cycle after that write, and read_mode becomes status (1). Status mode is kept when the WSM busy inputs later fall.
- R3: The six-write form is unlock, 80h to 5555h, unlock, then a final write to low address 5555h. A final code of 10h requests chip erase (req_op 2). A final code of 30h requests sector erase (req_op 3). On every request, req_sector carries address bits 18..16 of the final write.
- R4: Set-up code 60h followed by final code 20h requests sector protect (req_op 4). Final code 40h requests sector unprotect (req_op 5). Either is accepted only for sector 000b or 111b. For any other sector nothing changes.
- R5: Three-write codes 90h, C0h and E0h issue read-ID (req_op 6, read_mode 2), sleep (req_op 7) and abort (req_op 8). Sleep and abort set read_mode to status.
- R6: Three-write code F0h selects array reads (read_mode 0). Code 70h selects status reads (read_mode 1). Neither issues a request.
- R7: While wsm_prog_busy is high and no erase is suspended, only read-status and abort are accepted.
- R8: While wsm_erase_busy is high and no erase is suspended, only read-status, abort and erase suspend (code B0h, req_op 9) are accepted. An accepted suspend sets erase_suspended.
- R9: While erase_suspended is high, only read-array, read-status, abort and erase resume (code D0h, req_op 10) are accepted. Sleep is among the commands ignored. Resume or abort clears erase_suspended.
- R10: With no suspension in force, resume has no effect. With the WSM idle, abort has no effect.
- R11: A write that breaks the expected sequence returns the decoder to waiting for the first unlock write. That write issues nothing and does not count toward a new sequence.
- R12: After reset, req_valid is 0, req_op is 0, req_sector is 0, read_mode is array (0) and erase_suspended is 0.
- R13: req_valid is high for exactly one cycle per accepted request. It is high only in the cycle after a host write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W (19) | Host write address |
| wr_data | input | 8 | Host write data byte |
| wsm_prog_busy | input | 1 | WSM is running a program operation |
| wsm_erase_busy | input | 1 | WSM is running an erase operation |
| req_valid | output | 1 | One-cycle request strobe to the WSM |
| req_op | output | 4 | Requested operation code, 0 when idle |
| req_sector | output | SEC_W (3) | Sector field of the final write |
| read_mode | output | 2 | Read path: 0 array, 1 status, 2 identifier |
| erase_suspended | output | 1 | An erase suspend is in force |

## Verification
Every result of this block is registered once. The request, the read mode and the suspend flag therefore change on the first rising edge after the final write of a sequence, and nowhere else. Writes are presented just after a falling edge. The outputs are compared against the reference model at the next falling edge, which is half a period after the edge that must have produced them. Idle cycles are compared the same way, so a request that lingers a second cycle or appears without a write is caught in the very cycle it occurs.

// File: rtl/cmdseq_pkg.sv
`timescale 1ns/1ps
package cmdseq_pkg;

   typedef enum logic [3:0] {
      OP_NONE       = 4'd0,
      OP_PROGRAM    = 4'd1,
      OP_CHIP_ERASE = 4'd2,
      OP_SECT_ERASE = 4'd3,
      OP_PROTECT    = 4'd4,
      OP_UNPROTECT  = 4'd5,
      OP_READ_ID    = 4'd6,
      OP_SLEEP      = 4'd7,
      OP_ABORT      = 4'd8,
      OP_SUSPEND    = 4'd9,
      OP_RESUME     = 4'd10,
      OP_RD_ARRAY   = 4'd11,
      OP_RD_STATUS  = 4'd12
   } op_e;

   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_STATUS = 2'd1,
      MODE_ID     = 2'd2
   } mode_e;

   localparam logic [7:0] KEY_DATA_A   = 8'hAA;
   localparam logic [7:0] KEY_DATA_B   = 8'h55;
   localparam logic [7:0] SET_ERASE    = 8'h80;
   localparam logic [7:0] SET_GUARD    = 8'h60;
   localparam logic [7:0] C_PROGRAM    = 8'hA0;
   localparam logic [7:0] C_READ_ID    = 8'h90;
   localparam logic [7:0] C_SLEEP      = 8'hC0;
   localparam logic [7:0] C_ABORT      = 8'hE0;
   localparam logic [7:0] C_RD_ARRAY   = 8'hF0;
   localparam logic [7:0] C_RD_STATUS  = 8'h70;
   localparam logic [7:0] C_SUSPEND    = 8'hB0;
   localparam logic [7:0] C_RESUME     = 8'hD0;
   localparam logic [7:0] C_CHIP_ERASE = 8'h10;
   localparam logic [7:0] C_SECT_ERASE = 8'h30;
   localparam logic [7:0] C_PROTECT    = 8'h20;
   localparam logic [7:0] C_UNPROTECT  = 8'h40;

   function automatic logic is_request(op_e op);
      return (op != OP_NONE) && (op != OP_RD_ARRAY) && (op != OP_RD_STATUS);
   endfunction

endpackage

// File: rtl/cmdseq_match.sv
`timescale 1ns/1ps
module cmdseq_match
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int CMP_W   = 15,
   parameter int SEC_LSB = 16,
   parameter int SEC_W   = 3,
   parameter int KEY_A   = 'h5555,
   parameter int KEY_B   = 'h2AAA
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              key_a_hit,
   output logic              key_b_hit,
   output logic              cmd_addr_hit,
   output logic [SEC_W-1:0]  sector
);
   localparam int SEC_HI = SEC_LSB + SEC_W - 1;
   localparam logic [CMP_W-1:0] KEY_A_V = CMP_W'(KEY_A);
   localparam logic [CMP_W-1:0] KEY_B_V = CMP_W'(KEY_B);

   logic [CMP_W-1:0] low;
   assign low          = wr_addr[CMP_W-1:0];
   assign cmd_addr_hit = (low == KEY_A_V);
   assign key_a_hit    = cmd_addr_hit && (wr_data == KEY_DATA_A);
   assign key_b_hit    = (low == KEY_B_V) && (wr_data == KEY_DATA_B);
   assign sector       = wr_addr[SEC_HI:SEC_LSB];

   // address bits between the compare field and the sector field, and above it
   logic unused_gap_bits;
   generate
      if (SEC_LSB > CMP_W) begin : g_gap
         assign unused_gap_bits = ^wr_addr[SEC_LSB-1:CMP_W];
      end else begin : g_nogap
         assign unused_gap_bits = 1'b0;
      end
      if (ADDR_W > SEC_HI + 1) begin : g_top
         logic unused_top_bits;
         assign unused_top_bits = ^wr_addr[ADDR_W-1:SEC_HI+1];
      end
   endgenerate
endmodule

// File: rtl/cmdseq_fsm.sv
`timescale 1ns/1ps
module cmdseq_fsm
   import cmdseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       key_a_hit,
   input  logic       key_b_hit,
   input  logic       cmd_addr_hit,
   output logic       cand_v,
   output op_e        cand_op
);
   typedef enum logic [2:0] {
      ST_IDLE, ST_K1, ST_K2, ST_SET, ST_SK1, ST_SK2
   } st_e;

   st_e  st_q, st_d;
   logic guard_q, guard_d;   // 1: set-up was the protect form
   op_e  op3, op6;

   always_comb begin
      unique case (wr_data)
         C_PROGRAM:   op3 = OP_PROGRAM;
         C_READ_ID:   op3 = OP_READ_ID;
         C_SLEEP:     op3 = OP_SLEEP;
         C_ABORT:     op3 = OP_ABORT;
         C_RD_ARRAY:  op3 = OP_RD_ARRAY;
         C_RD_STATUS: op3 = OP_RD_STATUS;
         C_SUSPEND:   op3 = OP_SUSPEND;
         C_RESUME:    op3 = OP_RESUME;
         default:     op3 = OP_NONE;
      endcase
   end

   always_comb begin
      op6 = OP_NONE;
      if (guard_q) begin
         if (wr_data == C_PROTECT)        op6 = OP_PROTECT;
         else if (wr_data == C_UNPROTECT) op6 = OP_UNPROTECT;
      end else begin
         if (wr_data == C_CHIP_ERASE)      op6 = OP_CHIP_ERASE;
         else if (wr_data == C_SECT_ERASE) op6 = OP_SECT_ERASE;
      end
   end

   always_comb begin
      st_d    = st_q;
      guard_d = guard_q;
      cand_op = OP_NONE;
      if (wr_en) begin
         st_d = ST_IDLE;
         unique case (st_q)
            ST_IDLE: if (key_a_hit) st_d = ST_K1;
            ST_K1:   if (key_b_hit) st_d = ST_K2;
            ST_K2: begin
               if (cmd_addr_hit) begin
                  if (wr_data == SET_ERASE || wr_data == SET_GUARD) begin
                     st_d    = ST_SET;
                     guard_d = (wr_data == SET_GUARD);
                  end else begin
                     cand_op = op3;
                  end
               end
            end
            ST_SET:  if (key_a_hit) st_d = ST_SK1;
            ST_SK1:  if (key_b_hit) st_d = ST_SK2;
            ST_SK2:  if (cmd_addr_hit) cand_op = op6;
            default: st_d = ST_IDLE;
         endcase
      end
   end
   assign cand_v = (cand_op != OP_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         guard_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         guard_q <= guard_d;
      end
   end
endmodule

// File: rtl/cmdseq_policy.sv
`timescale 1ns/1ps
module cmdseq_policy
   import cmdseq_pkg::*;
#(
   parameter int SEC_W       = 3,
   parameter bit PROTECT_ANY = 1'b0
) (
   input  logic             cand_v,
   input  op_e              cand_op,
   input  logic [SEC_W-1:0] sector,
   input  logic             prog_busy,
   input  logic             erase_busy,
   input  logic             suspended,
   output logic             accept
);
   logic sector_ok;
   logic state_ok;

   generate
      if (PROTECT_ANY) begin : g_any_sector
         assign sector_ok = 1'b1;
      end else begin : g_end_sectors
         assign sector_ok = (sector == '0) || (sector == '1);
      end
   endgenerate

   always_comb begin
      if (suspended)
         state_ok = cand_op inside {OP_RD_ARRAY, OP_RD_STATUS, OP_ABORT, OP_RESUME};
      else if (prog_busy)
         state_ok = cand_op inside {OP_RD_STATUS, OP_ABORT};
      else if (erase_busy)
         state_ok = cand_op inside {OP_RD_STATUS, OP_ABORT, OP_SUSPEND};
      else
         state_ok = !(cand_op inside {OP_ABORT, OP_SUSPEND, OP_RESUME});
   end

   assign accept = cand_v && state_ok &&
                   (sector_ok || !(cand_op inside {OP_PROTECT, OP_UNPROTECT}));
endmodule

// File: rtl/cmdseq_decoder.sv
`timescale 1ns/1ps
module cmdseq_decoder
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int CMP_W       = 15,
   parameter int SEC_LSB     = 16,
   parameter int SEC_W       = 3,
   parameter int KEY_A       = 'h5555,
   parameter int KEY_B       = 'h2AAA,
   parameter bit PROTECT_ANY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              wsm_prog_busy,
   input  logic              wsm_erase_busy,
   output logic              req_valid,
   output logic [3:0]        req_op,
   output logic [SEC_W-1:0]  req_sector,
   output logic [1:0]        read_mode,
   output logic              erase_suspended
);
   generate
      if (ADDR_W < SEC_LSB + SEC_W) begin : g_bad_addr_w
         $error("ADDR_W too small to hold the sector field");
      end
      if (CMP_W > SEC_LSB) begin : g_bad_cmp_w
         $error("compare field overlaps the sector field");
      end
   endgenerate

   logic             key_a_hit, key_b_hit, cmd_addr_hit, cand_v, accept;
   logic [SEC_W-1:0] sector;
   op_e              cand_op;
   mode_e            mode_q;

   cmdseq_match #(
      .ADDR_W(ADDR_W), .CMP_W(CMP_W), .SEC_LSB(SEC_LSB), .SEC_W(SEC_W),
      .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_match (
      .wr_addr(wr_addr), .wr_data(wr_data),
      .key_a_hit(key_a_hit), .key_b_hit(key_b_hit),
      .cmd_addr_hit(cmd_addr_hit), .sector(sector)
   );

   cmdseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .key_a_hit(key_a_hit), .key_b_hit(key_b_hit), .cmd_addr_hit(cmd_addr_hit),
      .cand_v(cand_v), .cand_op(cand_op)
   );

   cmdseq_policy #(.SEC_W(SEC_W), .PROTECT_ANY(PROTECT_ANY)) u_policy (
      .cand_v(cand_v), .cand_op(cand_op), .sector(sector),
      .prog_busy(wsm_prog_busy), .erase_busy(wsm_erase_busy),
      .suspended(erase_suspended), .accept(accept)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid       <= 1'b0;
         req_op          <= OP_NONE;
         req_sector      <= '0;
         mode_q          <= MODE_ARRAY;
         erase_suspended <= 1'b0;
      end else begin
         req_valid  <= accept && is_request(cand_op);
         req_op     <= (accept && is_request(cand_op)) ? cand_op : OP_NONE;
         req_sector <= (accept && is_request(cand_op)) ? sector : '0;
         if (accept) begin
            unique case (cand_op)
               OP_RD_ARRAY: mode_q <= MODE_ARRAY;
               OP_READ_ID:  mode_q <= MODE_ID;
               default:     mode_q <= MODE_STATUS;
            endcase
            if (cand_op == OP_SUSPEND)
               erase_suspended <= 1'b1;
            else if (cand_op == OP_RESUME || cand_op == OP_ABORT)
               erase_suspended <= 1'b0;
         end
      end
   end
   assign read_mode = mode_q;
endmodule

// File: rtl/cmdseq_decoder_chk.sv
`timescale 1ns/1ps
module cmdseq_decoder_chk
   import cmdseq_pkg::*;
#(
   parameter int SEC_W       = 3,
   parameter bit PROTECT_ANY = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wsm_prog_busy,
   input logic             wsm_erase_busy,
   input logic             req_valid,
   input logic [3:0]       req_op,
   input logic [SEC_W-1:0] req_sector,
   input logic [1:0]       read_mode,
   input logic             erase_suspended
);
   assert_req_follows_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !req_valid);

   assert_req_has_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_op != OP_NONE) && (req_op <= OP_RESUME));

   assert_guard_sector_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == OP_PROTECT || req_op == OP_UNPROTECT) && !PROTECT_ANY)
      |-> (req_sector == '0 || req_sector == '1));

   assert_prog_busy_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(wsm_prog_busy) && !$past(erase_suspended))
      |-> (req_op == OP_ABORT));

   assert_suspend_needs_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_SUSPEND) |-> $past(wsm_erase_busy) && erase_suspended);

   assert_suspend_rises_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_suspended) |-> (req_valid && req_op == OP_SUSPEND));

   assert_no_sleep_in_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(erase_suspended)) |-> (req_op == OP_ABORT || req_op == OP_RESUME));

   assert_resume_needs_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_RESUME) |-> $past(erase_suspended) && !erase_suspended);

   assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      read_mode != 2'd3);
endmodule

bind cmdseq_decoder cmdseq_decoder_chk #(.SEC_W(SEC_W), .PROTECT_ANY(PROTECT_ANY)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
   .wsm_prog_busy(wsm_prog_busy), .wsm_erase_busy(wsm_erase_busy),
   .req_valid(req_valid), .req_op(req_op), .req_sector(req_sector),
   .read_mode(read_mode), .erase_suspended(erase_suspended)
);

// File: tb/cmdseq_decoder_bench.sv
`timescale 1ns/1ps
module cmdseq_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        pbusy = 1'b0;
   logic        ebusy = 1'b0;
   logic        req_valid, erase_suspended;
   logic [3:0]  req_op;
   logic [2:0]  req_sector;
   logic [1:0]  read_mode;

   always #2.5 clk = ~clk;

   cmdseq_decoder u_cmdseq_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wsm_prog_busy(pbusy), .wsm_erase_busy(ebusy),
      .req_valid(req_valid), .req_op(req_op), .req_sector(req_sector),
      .read_mode(read_mode), .erase_suspended(erase_suspended)
   );

   int checks = 0, fails = 0;
   // reference model state
   int st = 0, setup = 0, ereq = 0, eop = 0, esec = 0, emode = 0, esusp = 0;

   function automatic int code3(int d);
      case (d)
         'hA0: return 1;  'h90: return 6;  'hC0: return 7;  'hE0: return 8;
         'hB0: return 9;  'hD0: return 10; 'hF0: return 11; 'h70: return 12;
         default: return 0;
      endcase
   endfunction

   function automatic int code6(int s, int d);
      if (s == 'h80) return (d == 'h10) ? 2 : (d == 'h30) ? 3 : 0;
      return (d == 'h20) ? 4 : (d == 'h40) ? 5 : 0;
   endfunction

   function automatic bit allowed(int op, int sec);
      if ((op == 4 || op == 5) && !(sec == 0 || sec == 7)) return 0;
      if (esusp != 0) return op == 11 || op == 12 || op == 8 || op == 10;
      if (pbusy)      return op == 12 || op == 8;
      if (ebusy)      return op == 12 || op == 9 || op == 8;
      return !(op == 8 || op == 9 || op == 10);
   endfunction

   task automatic model(int a, int d);
      int lo  = a & 'h7FFF;
      int sec = (a >> 16) & 7;
      int op  = 0;
      ereq = 0; eop = 0; esec = 0;
      case (st)
         0: st = (lo == 'h5555 && d == 'hAA) ? 1 : 0;
         1: st = (lo == 'h2AAA && d == 'h55) ? 2 : 0;
         2: begin
            st = 0;
            if (lo == 'h5555) begin
               if (d == 'h80 || d == 'h60) begin setup = d; st = 3; end
               else op = code3(d);
            end
         end
         3: st = (lo == 'h5555 && d == 'hAA) ? 4 : 0;
         4: st = (lo == 'h2AAA && d == 'h55) ? 5 : 0;
         default: begin
            st = 0;
            if (lo == 'h5555) op = code6(setup, d);
         end
      endcase
      if (op != 0 && allowed(op, sec)) begin
         if (op <= 10) begin ereq = 1; eop = op; esec = sec; end
         emode = (op == 11) ? 0 : (op == 6) ? 2 : 1;
         if (op == 9) esusp = 1;
         else if (op == 10 || op == 8) esusp = 0;
      end
   endtask

   task automatic compare(string tag);
      checks++;
      if (req_valid !== ereq[0] || req_op !== eop[3:0] || req_sector !== esec[2:0] ||
          read_mode !== emode[1:0] || erase_suspended !== esusp[0]) begin
         fails++;
         $display("FAIL %s: got v=%0d op=%0d sec=%0d mode=%0d susp=%0d, expected v=%0d op=%0d sec=%0d mode=%0d susp=%0d",
                  tag, req_valid, req_op, req_sector, read_mode, erase_suspended,
                  ereq, eop, esec, emode, esusp);
      end
   endtask

   task automatic wr(int a, int d, string tag);
      wr_en = 1'b1; wr_addr = a[18:0]; wr_data = d[7:0];
      model(a, d);
      @(negedge clk);
      wr_en = 1'b0;
      compare(tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) begin
         ereq = 0; eop = 0; esec = 0;
         @(negedge clk);
         compare(tag);
      end
   endtask

   task automatic cmd3(int code, int hi, string tag);
      wr('h5555, 'hAA, tag);
      wr('h2AAA, 'h55, tag);
      wr((hi << 15) | 'h5555, code, tag);
      idle(1, tag);
   endtask

   task automatic cmd6(int set, int code, int sec, string tag);
      wr('h5555, 'hAA, tag);
      wr('h2AAA, 'h55, tag);
      wr('h5555, set, tag);
      wr('h5555, 'hAA, tag);
      wr('h2AAA, 'h55, tag);
      wr((sec << 16) | 'h5555, code, tag);
      idle(1, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R12 reset state");
      // R1: upper address bits on unlock writes and command write are ignored
      wr('h7D555, 'hAA, "R1");
      wr('h4AAAA, 'h55, "R1");
      wr('h5555, 'hA0, "R1 R2 program");
      idle(1, "R13 single cycle");
      cmd3('hF0, 0, "R6 read array");
      cmd3('hA0, 13, "R2 program hi bits");
      pbusy = 1'b1;
      cmd3('h90, 0, "R7 id rejected");
      cmd3('hF0, 0, "R7 array rejected");
      cmd3('h70, 0, "R7 status ok");
      cmd6('h80, 'h10, 0, "R7 erase rejected");
      cmd3('hB0, 0, "R7 suspend rejected");
      cmd3('hE0, 0, "R7 abort ok");
      pbusy = 1'b0;
      idle(2, "R2 status kept");
      cmd3('hF0, 0, "R6 read array");
      cmd6('h80, 'h10, 2, "R3 chip erase");
      cmd6('h80, 'h30, 5, "R3 sector erase");
      cmd6('h80, 'h20, 5, "R3 wrong final code");
      cmd6('h60, 'h20, 7, "R4 protect top");
      cmd6('h60, 'h40, 0, "R4 unprotect bottom");
      cmd6('h60, 'h20, 3, "R4 bad sector");
      cmd6('h60, 'h10, 0, "R4 wrong final code");
      cmd3('h90, 0, "R5 read id");
      cmd3('hC0, 0, "R5 sleep");
      cmd3('h90, 0, "R5 read id");
      cmd3('hE0, 0, "R10 abort idle");
      cmd3('hD0, 0, "R10 resume idle");
      cmd3('hB0, 0, "R10 suspend idle");
      cmd3('h70, 0, "R6 read status");
      // R11: sequence breaks
      wr('h5555, 'hAA, "R11");
      wr('h2AAA, 'h00, "R11 bad data");
      wr('h2AAA, 'h55, "R11 discarded");
      wr('h5555, 'hF0, "R11 no effect");
      wr('h5554, 'hAA, "R11 bad addr");
      wr('h2AAA, 'h55, "R11");
      wr('h5555, 'hF0, "R11 no effect");
      wr('h5555, 'hAA, "R11");
      wr('h2AAA, 'h55, "R11");
      wr('h5555, 'h80, "R11");
      wr('h5555, 'hAA, "R11");
      wr('h5555, 'hAA, "R11 break in second unlock");
      wr('h2AAA, 'h55, "R11");
      wr('h5555, 'h30, "R11 no effect");
      idle(1, "R11");
      cmd3('hF0, 0, "R6 read array");
      // erase in progress
      ebusy = 1'b1;
      cmd3('hC0, 0, "R8 sleep rejected");
      cmd3('hA0, 0, "R8 program rejected");
      cmd3('hD0, 0, "R10 resume without suspend");
      cmd3('hB0, 0, "R8 suspend");
      cmd3('hB0, 0, "R9 second suspend rejected");
      cmd3('hC0, 0, "R9 sleep ignored");
      cmd3('hA0, 0, "R9 program ignored");
      cmd6('h80, 'h30, 1, "R9 erase ignored");
      cmd3('hF0, 0, "R9 read array ok");
      cmd3('h90, 0, "R9 id ignored");
      cmd3('h70, 0, "R9 read status ok");
      cmd3('hD0, 0, "R9 resume");
      cmd3('hB0, 0, "R8 suspend again");
      cmd3('hE0, 0, "R9 abort clears");
      cmd3('hE0, 0, "R8 abort during erase");
      ebusy = 1'b0;
      idle(2, "R2 status kept");
      // back-to-back sequences without gaps
      wr('h5555, 'hAA, "R13");
      wr('h2AAA, 'h55, "R13");
      wr('h5555, 'hA0, "R13");
      wr('h5555, 'hAA, "R13 next starts");
      wr('h2AAA, 'h55, "R13");
      wr('h5555, 'h90, "R13");
      idle(2, "R13");
      rst_n = 1'b0;
      st = 0; ereq = 0; eop = 0; esec = 0; emode = 0; esusp = 0;
      @(negedge clk);
      rst_n = 1'b1;
      idle(1, "R12 reset clears mode");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule